// File: doc/BRIEF.md
# Two-Input Persistency Filter

This block removes short glitches from two independent digital status inputs, A and B, before they reach an interrupt controller. Each input has its own 8-bit duration setting. A change of level is accepted only after the new level has held through the programmed number of 64 µs units. When a change is accepted, the filtered level moves to the new value and a one-cycle change pulse is raised for that input. A change that reverts before the programmed time produces no pulse and leaves the filtered level unchanged.

Both inputs pass through a two-flop synchronizer. They are then sampled on a 32 µs strobe. The strobe either comes from a pin or from an internal clock divider, and a parameter picks which. One 64 µs unit equals two strobes, so a setting of T requires 2·T consecutive samples at the new level. A setting of zero turns filtering off: the first sample that differs is accepted at once.

Top module: `input_persist_filter`

## Requirements
- R1: After reset is released, `level_out` takes the synchronized values of `raw_in` within three clock cycles and no `change_pulse` is raised for this initial load.
- R2: Each raw input passes through two flip-flops before it is used. A sample strobe on the first or second clock edge after a raw change still sees the old level. The strobe on the third edge sees the new level.
- R3: With a setting T between 1 and 255, a change is accepted on the strobe that gives the 2·T-th consecutive sample differing from `level_out`. No earlier strobe accepts it.
- R4: A sample equal to `level_out` clears the running count. A change that lasts fewer than 2·T samples produces no pulse and leaves `level_out` unchanged.
- R5: With a setting of zero, the first strobe whose sample differs from `level_out` accepts the change.
- R6: `change_pulse[i]` is high for exactly one clock cycle, in the cycle that follows the accepting strobe edge. In that same cycle `level_out[i]` holds the new level. Bit 0 is input A and bit 1 is input B.
- R7: If the setting of an input changes value, that input's running count restarts from zero.
- R8: Inputs A and B are filtered independently. Each uses its own setting (`thr_a` for bit 0, `thr_b` for bit 1) and each has its own count.
- R9: With `EXT_TICK = 0`, an internal divider raises one sample strobe every `TICK_DIV` clock cycles and `ext_tick` is ignored. With `EXT_TICK = 1`, `ext_tick` is used as the strobe directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_tick | input | 1 | External 32 µs sample strobe, one cycle wide (used when EXT_TICK = 1) |
| raw_in | input | 2 | Unfiltered inputs; bit 0 is A, bit 1 is B |
| thr_a | input | 8 | Minimum duration for A, in 64 µs units; 0 turns filtering off |
| thr_b | input | 8 | Minimum duration for B, in 64 µs units; 0 turns filtering off |
| level_out | output | 2 | Filtered (accepted) levels |
| change_pulse | output | 2 | One-cycle pulse per input when a change is accepted |

## Verification
The bound checker checks the following on every cycle:
- a pulse appears only right after a strobe edge;
- every change of the filtered level comes with its pulse, and every pulse comes with a change of level;
- each running count stays below twice its setting;
- a matching sample always clears the count;
- a zero setting accepts a differing sample on the next edge.

Only the directed scenarios can show the following:
- the exact strobe on which a change is accepted;
- that a glitch shorter than the window leaves no trace;
- that rewriting a setting restarts the window;
- the two-edge synchronizer latency;
- the initial load after reset;
- the spacing of the internal strobe.

// File: rtl/persist_pkg.sv
package persist_pkg;

  // width of one duration setting
  localparam int unsigned THR_W = 8;
  // running count must hold 2*(2^THR_W - 1)
  localparam int unsigned CNT_W = THR_W + 1;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,  // nothing to do this cycle
    ACT_CLEAR  = 2'd1,  // count back to zero
    ACT_COUNT  = 2'd2,  // one more differing sample
    ACT_ACCEPT = 2'd3   // new level accepted
  } ch_action_e;

  // number of 32 us samples that form the programmed window
  function automatic logic [CNT_W-1:0] window_samples(input logic [THR_W-1:0] thr);
    return {thr, 1'b0};
  endfunction

  // true when the sample count reached after this strobe closes the window
  function automatic logic window_closed(input logic [CNT_W-1:0] next_cnt,
                                         input logic [THR_W-1:0] thr);
    if (thr == '0) return 1'b1;
    return next_cnt >= window_samples(thr);
  endfunction

endpackage

// File: rtl/persist_sync2.sv
module persist_sync2 #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;

endmodule

// File: rtl/persist_tick_gen.sv
module persist_tick_gen #(
  parameter int unsigned TICK_DIV = 4000,
  parameter bit          EXT_TICK = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_tick,
  output logic tick
);

  generate
    if (EXT_TICK) begin : g_ext
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign tick = ext_tick;
    end else begin : g_div
      localparam int unsigned DW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
      localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);

      logic [DW-1:0] div_cnt;
      logic          unused_ext;

      assign unused_ext = ext_tick;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          div_cnt <= '0;
        end else if (div_cnt == LAST) begin
          div_cnt <= '0;
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end

      assign tick = (div_cnt == LAST);
    end
  endgenerate

endmodule

// File: rtl/persist_channel.sv
module persist_channel
  import persist_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ready,
  input  logic             tick,
  input  logic             smp,
  input  logic [THR_W-1:0] thr,
  output logic             level,
  output logic             pulse,
  output logic [CNT_W-1:0] run_cnt,
  output ch_action_e       action
);

  logic [THR_W-1:0] thr_q;
  logic             thr_moved;
  logic [CNT_W-1:0] cnt_next;

  assign thr_moved = (thr != thr_q);
  assign cnt_next  = run_cnt + 1'b1;

  always_comb begin
    if (!ready) begin
      action = ACT_HOLD;
    end else if (thr_moved) begin
      action = ACT_CLEAR;
    end else if (!tick) begin
      action = ACT_HOLD;
    end else if (smp == level) begin
      action = ACT_CLEAR;
    end else if (window_closed(cnt_next, thr)) begin
      action = ACT_ACCEPT;
    end else begin
      action = ACT_COUNT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level   <= 1'b0;
      pulse   <= 1'b0;
      run_cnt <= '0;
      thr_q   <= '0;
    end else if (!ready) begin
      level   <= smp;
      pulse   <= 1'b0;
      run_cnt <= '0;
      thr_q   <= thr;
    end else begin
      thr_q <= thr;
      pulse <= 1'b0;
      unique case (action)
        ACT_CLEAR:  run_cnt <= '0;
        ACT_COUNT:  run_cnt <= cnt_next;
        ACT_ACCEPT: begin
          run_cnt <= '0;
          level   <= smp;
          pulse   <= 1'b1;
        end
        default:    run_cnt <= run_cnt;
      endcase
    end
  end

endmodule

// File: rtl/input_persist_filter.sv
module input_persist_filter
  import persist_pkg::*;
#(
  parameter int unsigned TICK_DIV = 4000,
  parameter bit          EXT_TICK = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_tick,
  input  logic [1:0]       raw_in,
  input  logic [THR_W-1:0] thr_a,
  input  logic [THR_W-1:0] thr_b,
  output logic [1:0]       level_out,
  output logic [1:0]       change_pulse
);

  localparam int unsigned N_CH = 2;

  // named internal events, brought out for the checker
  logic                 smp_tick;
  logic [N_CH-1:0]      sync_lvl;
  logic                 ready;
  logic [1:0]           settle;
  logic [THR_W-1:0]     thr_vec [N_CH];
  logic [CNT_W-1:0]     run_cnt [N_CH];
  ch_action_e           ch_act  [N_CH];
  logic [CNT_W-1:0]     run_cnt_a;
  logic [CNT_W-1:0]     run_cnt_b;

  assign thr_vec[0] = thr_a;
  assign thr_vec[1] = thr_b;
  assign run_cnt_a  = run_cnt[0];
  assign run_cnt_b  = run_cnt[1];

  persist_tick_gen #(
    .TICK_DIV (TICK_DIV),
    .EXT_TICK (EXT_TICK)
  ) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_tick (ext_tick),
    .tick     (smp_tick)
  );

  persist_sync2 #(.W(N_CH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (sync_lvl)
  );

  // wait until the synchronizer holds real input values
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle <= '0;
    end else if (settle != 2'd3) begin
      settle <= settle + 1'b1;
    end
  end

  assign ready = (settle == 2'd3);

  generate
    for (genvar i = 0; i < N_CH; i++) begin : g_ch
      persist_channel u_ch (
        .clk     (clk),
        .rst_n   (rst_n),
        .ready   (ready),
        .tick    (smp_tick),
        .smp     (sync_lvl[i]),
        .thr     (thr_vec[i]),
        .level   (level_out[i]),
        .pulse   (change_pulse[i]),
        .run_cnt (run_cnt[i]),
        .action  (ch_act[i])
      );
    end
  endgenerate

endmodule

// File: rtl/persist_filter_chk.sv
module persist_filter_chk
  import persist_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ready,
  input logic             smp_tick,
  input logic [1:0]       sync_lvl,
  input logic [1:0]       level_out,
  input logic [1:0]       change_pulse,
  input logic [THR_W-1:0] thr_a,
  input logic [THR_W-1:0] thr_b,
  input logic [CNT_W-1:0] run_cnt_a,
  input logic [CNT_W-1:0] run_cnt_b
);

  // R6: pulses only follow a strobe edge
  p_pulse_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (change_pulse != 2'b00) |-> $past(smp_tick));

  // R6: level moves exactly when a pulse is raised
  p_level_pulse_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ready) |-> (change_pulse == (level_out ^ $past(level_out))));

  // R3: count never reaches the window
  p_cnt_bound_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (($past(thr_a) == '0) ? (run_cnt_a == '0)
                                    : (run_cnt_a < {$past(thr_a), 1'b0})));
  p_cnt_bound_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (($past(thr_b) == '0) ? (run_cnt_b == '0)
                                    : (run_cnt_b < {$past(thr_b), 1'b0})));

  // R4: a matching sample clears the count
  p_match_clears_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ready && smp_tick && (sync_lvl[0] == level_out[0])) |-> (run_cnt_a == '0));
  p_match_clears_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ready && smp_tick && (sync_lvl[1] == level_out[1])) |-> (run_cnt_b == '0));

  // R5: zero setting accepts on the first differing sample
  p_bypass_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && smp_tick && (thr_a == '0) && ($past(thr_a) == '0) &&
     (sync_lvl[0] != level_out[0])) |=> change_pulse[0]);
  p_bypass_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && smp_tick && (thr_b == '0) && ($past(thr_b) == '0) &&
     (sync_lvl[1] != level_out[1])) |=> change_pulse[1]);

endmodule

bind input_persist_filter persist_filter_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ready        (ready),
  .smp_tick     (smp_tick),
  .sync_lvl     (sync_lvl),
  .level_out    (level_out),
  .change_pulse (change_pulse),
  .thr_a        (thr_a),
  .thr_b        (thr_b),
  .run_cnt_a    (run_cnt_a),
  .run_cnt_b    (run_cnt_b)
);

// File: tb/test_input_persist_filter.sv
module test_input_persist_filter;

  localparam int DIV2 = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_tick = 1'b0;
  logic [1:0] raw_in = 2'b10;
  logic [7:0] thr_a = 8'd0;
  logic [7:0] thr_b = 8'd0;
  logic [1:0] level_out;
  logic [1:0] change_pulse;

  logic [1:0] raw_d = 2'b00;
  logic [7:0] thr_d = 8'd1;
  logic [1:0] level_d;
  logic [1:0] pulse_d;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  input_persist_filter #(.TICK_DIV(4), .EXT_TICK(1'b1)) i_input_persist_filter (
    .clk (clk), .rst_n (rst_n), .ext_tick (ext_tick), .raw_in (raw_in),
    .thr_a (thr_a), .thr_b (thr_b), .level_out (level_out), .change_pulse (change_pulse)
  );

  input_persist_filter #(.TICK_DIV(DIV2), .EXT_TICK(1'b0)) i_div_variant (
    .clk (clk), .rst_n (rst_n), .ext_tick (1'b1), .raw_in (raw_d),
    .thr_a (thr_d), .thr_b (thr_d), .level_out (level_d), .change_pulse (pulse_d)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_up();
    end
  end

  // one strobe edge; returns at the negedge after it
  task automatic tick_once();
    @(negedge clk) ext_tick = 1'b1;
    @(negedge clk) ext_tick = 1'b0;
  endtask

  task automatic settle_sync();
    repeat (3) @(negedge clk);
  endtask

  // n strobes, each expected to leave channel ch quiet
  task automatic quiet_ticks(input int n, input int ch, input string req);
    int bad = 0;
    for (int k = 0; k < n; k++) begin
      tick_once();
      if (change_pulse[ch]) bad++;
    end
    chk(req, bad, 0);
  endtask

  task automatic t_reset();
    int seen = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (change_pulse != 2'b00) seen++;
    end
    chk("R1 level after reset", level_out, 2);
    chk("R1 no pulse on initial load", seen, 0);
  endtask

  task automatic t_sync_latency();
    thr_a = 8'd0;
    settle_sync();
    @(negedge clk);
    raw_in[0] = 1'b1;
    ext_tick = 1'b1;
    @(negedge clk);
    chk("R2 first edge sees old level", change_pulse[0], 0);
    @(negedge clk);
    chk("R2 second edge sees old level", change_pulse[0], 0);
    @(negedge clk);
    ext_tick = 1'b0;
    chk("R2 third edge sees new level", change_pulse[0], 1);
    chk("R2 level after third edge", level_out[0], 1);
  endtask

  task automatic t_duration();
    thr_a = 8'd3;
    settle_sync();
    raw_in[0] = 1'b0;
    settle_sync();
    quiet_ticks(5, 0, "R3 no early accept T=3");
    chk("R3 level held before window", level_out[0], 1);
    tick_once();
    chk("R3 accept on sample 6", change_pulse[0], 1);
    chk("R6 level with pulse", level_out[0], 0);
    @(negedge clk);
    chk("R6 pulse one cycle", change_pulse[0], 0);
    thr_b = 8'd255;
    settle_sync();
    raw_in[1] = 1'b0;
    settle_sync();
    quiet_ticks(509, 1, "R3 no early accept T=255");
    tick_once();
    chk("R3 accept on sample 510", change_pulse[1], 1);
    chk("R3 level B after 510", level_out[1], 0);
  endtask

  task automatic t_glitch();
    thr_a = 8'd3;
    settle_sync();
    raw_in[0] = 1'b1;
    settle_sync();
    quiet_ticks(5, 0, "R4 glitch part one");
    raw_in[0] = 1'b0;
    settle_sync();
    quiet_ticks(1, 0, "R4 matching sample");
    chk("R4 level unchanged by glitch", level_out[0], 0);
    raw_in[0] = 1'b1;
    settle_sync();
    quiet_ticks(5, 0, "R4 count restarted");
    tick_once();
    chk("R4 accept after full new window", change_pulse[0], 1);
  endtask

  task automatic t_bypass();
    thr_b = 8'd0;
    settle_sync();
    raw_in[1] = 1'b1;
    settle_sync();
    tick_once();
    chk("R5 zero setting accepts at once", change_pulse[1], 1);
    chk("R5 level B", level_out[1], 1);
  endtask

  task automatic t_thr_change();
    thr_a = 8'd2;
    settle_sync();
    raw_in[0] = 1'b0;
    settle_sync();
    quiet_ticks(3, 0, "R7 before rewrite");
    thr_a = 8'd3;
    @(negedge clk);
    quiet_ticks(5, 0, "R7 restart after rewrite");
    tick_once();
    chk("R7 accept after new window", change_pulse[0], 1);
  endtask

  task automatic t_indep();
    thr_a = 8'd1;
    thr_b = 8'd4;
    settle_sync();
    raw_in = 2'b01;
    settle_sync();
    quiet_ticks(1, 0, "R8 A first sample");
    tick_once();
    chk("R8 A accepts on its own window", change_pulse, 1);
    quiet_ticks(5, 1, "R8 B still counting");
    chk("R8 B level held", level_out[1], 1);
    tick_once();
    chk("R8 B accepts on its own window", change_pulse, 2);
    chk("R8 both levels", level_out, 1);
  endtask

  task automatic t_divider();
    int n = 0;
    settle_sync();
    @(negedge clk);
    raw_d[0] = 1'b1;
    while (pulse_d[0] == 1'b0 && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk("R9 internal strobe window low", int'(n >= DIV2 + 3), 1);
    chk("R9 internal strobe window high", int'(n <= 2 * DIV2 + 2), 1);
    chk("R9 internal level", level_d[0], 1);
  endtask

  initial begin
    t_reset();
    t_sync_latency();
    t_duration();
    t_glitch();
    t_bypass();
    t_thr_change();
    t_indep();
    t_divider();
    finish_up();
  end

endmodule